// File: doc/BRIEF.md
# Cascaded CAM Flag and Result Arbiter

This block sits in each device of a vertical chain of content-addressable memories. It takes the local search summary of its own array (whether anything hit, whether two or more entries hit, and the winning local index), the array's all-entries-valid indication and next-free index, and joins them with the match and full indications coming from the higher-priority neighbour. It produces the chained match and full flags, a pull request for the shared multiple-match line, and decides whether this device owns the shared page:index result bus.

All chain signals are active high here. The highest-priority device ties its match input low and its full input high. Each operation is presented for one clock with the chip-enable input high. Compare, next-free write and random access load the result state. The no-op code, which stands for register traffic, leaves it alone. While chip enable is low, no state changes.

Top module: `cam_cascade_arbiter`

## Requirements
- R1: `match_out` is high whenever `match_in` is high, and otherwise follows the local hit stored by the last compare.
- R2: `full_out` is high only when `all_valid` and `full_in` are both high, and `full_in` low forces it low.
- R3: `mm_pull` equals the stored local hit when `match_in` is high, and the stored two-or-more indication when `match_in` is low.
- R4: After a compare (op code 01), the device drives `{page, loc_idx}` as captured at the compare only if its stored hit is set and `match_in` is low. Any other device stays off.
- R5: After a compare that hit nowhere in the system, only a device with `cfg_lowest` high drives all ones. This case shows at the device as no stored hit and `match_in` low.
- R6: After a next-free write (op code 10), the device drives `{page, free_idx}` if at the write `full_in` was high and `all_valid` was low. If both were high, a device with `cfg_lowest` high drives all ones instead.
- R7: After a random access (op code 11) with `sel` high, the device drives `{page, acc_idx}` whatever the chain inputs say. With `sel` low, it releases the bus.
- R8: A compare with `sel` low clears any earlier local hit and two-or-more result.
- R9: The no-op code 00 leaves the stored hit, result address and ownership unchanged.
- R10: While `ce` is low, no operation code changes any stored state.
- R11: `res_oe` is low whenever `oe` is low.
- R12: After reset, there is no stored hit and `res_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Chip enable; state updates only while high |
| op | input | 2 | 00 none, 01 compare, 10 next-free write, 11 random access |
| sel | input | 1 | Device selected for this operation |
| loc_hit | input | 1 | Local array has at least one match |
| loc_multi | input | 1 | Local array has two or more matches |
| loc_idx | input | IDX_W | Highest-priority local match index |
| all_valid | input | 1 | Every local entry is valid |
| free_idx | input | IDX_W | Local next-free index |
| acc_idx | input | IDX_W | Random access index |
| page | input | PAGE_W | Page address of this device |
| match_in | input | 1 | Match indication from higher-priority neighbour |
| full_in | input | 1 | Full indication from higher-priority neighbour |
| oe | input | 1 | Result bus output enable |
| cfg_lowest | input | 1 | This device is lowest in the chain |
| match_out | output | 1 | Chained match flag |
| full_out | output | 1 | Chained full flag |
| mm_pull | output | 1 | Pull request for the wired-OR multiple-match line |
| res_bus | output | PAGE_W+IDX_W | Page:index result |
| res_oe | output | 1 | Drive enable for res_bus |

## Verification
The assertions assume that `loc_multi` never rises without `loc_hit`. They also assume that the chain inputs are settled levels, not glitching mid-cycle. The stimulus keeps to this: every compare that sets the multiple indication also sets the hit, and inputs change only on the falling clock edge. The bench counts the result bus as checked only in cycles where it expects the device to drive it.

// File: rtl/cam_cascade_arbiter.sv
module cam_cascade_arbiter #(
  parameter int IDX_W  = 6,
  parameter int PAGE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic [1:0]              op,
  input  logic                    sel,
  input  logic                    loc_hit,
  input  logic                    loc_multi,
  input  logic [IDX_W-1:0]        loc_idx,
  input  logic                    all_valid,
  input  logic [IDX_W-1:0]        free_idx,
  input  logic [IDX_W-1:0]        acc_idx,
  input  logic [PAGE_W-1:0]       page,
  input  logic                    match_in,
  input  logic                    full_in,
  input  logic                    oe,
  input  logic                    cfg_lowest,
  output logic                    match_out,
  output logic                    full_out,
  output logic                    mm_pull,
  output logic [PAGE_W+IDX_W-1:0] res_bus,
  output logic                    res_oe
);
  localparam int BW = PAGE_W + IDX_W;
  localparam logic [1:0] K_NONE = 2'd0, K_CMP = 2'd1, K_NFW = 2'd2, K_ACC = 2'd3;

  logic [1:0]    kind_q;
  logic          hit_q, multi_q, nfw_own_q, nfw_full_q;
  logic [BW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q     <= K_NONE;
      hit_q      <= 1'b0;
      multi_q    <= 1'b0;
      nfw_own_q  <= 1'b0;
      nfw_full_q <= 1'b0;
      addr_q     <= '0;
    end else if (ce) begin
      case (op)
        2'b01: begin
          kind_q  <= K_CMP;
          hit_q   <= sel & loc_hit;
          multi_q <= sel & loc_multi;
          addr_q  <= {page, loc_idx};
        end
        2'b10: begin
          kind_q     <= K_NFW;
          nfw_own_q  <= sel & full_in & ~all_valid;
          nfw_full_q <= sel & full_in & all_valid;
          addr_q     <= {page, free_idx};
        end
        2'b11: begin
          kind_q <= sel ? K_ACC : K_NONE;
          if (sel) addr_q <= {page, acc_idx};
        end
        default: ;
      endcase
    end
  end

  logic cmp_own, cmp_miss, nfw_own, nfw_full, ones;

  assign cmp_own  = (kind_q == K_CMP) & hit_q & ~match_in;
  assign cmp_miss = (kind_q == K_CMP) & ~hit_q & ~match_in & cfg_lowest;
  assign nfw_own  = (kind_q == K_NFW) & nfw_own_q;
  assign nfw_full = (kind_q == K_NFW) & nfw_full_q & cfg_lowest;
  assign ones     = cmp_miss | nfw_full;

  assign match_out = hit_q | match_in;
  assign full_out  = all_valid & full_in;
  assign mm_pull   = match_in ? hit_q : multi_q;
  assign res_oe    = oe & (cmp_own | nfw_own | (kind_q == K_ACC) | ones);
  assign res_bus   = ones ? {BW{1'b1}} : addr_q;
endmodule

// File: rtl/cam_cascade_arbiter_chk.sv
module cam_cascade_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce,
  input logic [1:0] op,
  input logic       sel,
  input logic       match_in,
  input logic       full_in,
  input logic       oe,
  input logic       match_out,
  input logic       full_out,
  input logic       mm_pull,
  input logic       res_oe,
  input logic       hit_q,
  input logic [1:0] kind_q,
  input logic [9:0] addr_lo
);
  a_r1_chain_match: assert property (@(posedge clk) disable iff (!rst_n)
    match_in |-> match_out);
  a_r2_full_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !full_in |-> !full_out);
  a_r3_multi_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    mm_pull |-> match_out);
  a_r4_lower_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (res_oe && kind_q == 2'd1 && hit_q) |-> !match_in);
  a_r8_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && op == 2'b01 && !sel) |=> !hit_q);
  a_r9_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce || op == 2'b00) |=> ($stable(hit_q) && $stable(kind_q) && $stable(addr_lo)));
  a_r11_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !res_oe);
endmodule

bind cam_cascade_arbiter cam_cascade_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .op(op), .sel(sel),
  .match_in(match_in), .full_in(full_in), .oe(oe),
  .match_out(match_out), .full_out(full_out), .mm_pull(mm_pull),
  .res_oe(res_oe), .hit_q(hit_q), .kind_q(kind_q), .addr_lo(addr_q[9:0])
);

// File: tb/tb_cam_cascade_arbiter.sv
module tb_cam_cascade_arbiter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce, sel, loc_hit, loc_multi, all_valid, match_in, full_in, oe, cfg_lowest;
  logic [1:0] op;
  logic [5:0] loc_idx, free_idx, acc_idx;
  logic [3:0] page;
  logic match_out, full_out, mm_pull, res_oe;
  logic [9:0] res_bus;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic mo, fo, mm, roe; logic [9:0] bus; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  cam_cascade_arbiter #(.IDX_W(6), .PAGE_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .op(op), .sel(sel), .loc_hit(loc_hit),
    .loc_multi(loc_multi), .loc_idx(loc_idx), .all_valid(all_valid),
    .free_idx(free_idx), .acc_idx(acc_idx), .page(page), .match_in(match_in),
    .full_in(full_in), .oe(oe), .cfg_lowest(cfg_lowest), .match_out(match_out),
    .full_out(full_out), .mm_pull(mm_pull), .res_bus(res_bus), .res_oe(res_oe));

  task automatic step(input logic [1:0] o, input logic c, s, h, m, input logic [5:0] li,
                      input logic av, input logic [5:0] fr, ac, input logic [3:0] pg,
                      input logic mi, fi, oen, lw,
                      input logic emo, efo, emm, eroe, input logic [9:0] ebus, input string tag);
    exp_t e;
    @(negedge clk);
    op = o; ce = c; sel = s; loc_hit = h; loc_multi = m; loc_idx = li; all_valid = av;
    free_idx = fr; acc_idx = ac; page = pg; match_in = mi; full_in = fi; oe = oen; cfg_lowest = lw;
    @(posedge clk);
    #1;
    e.mo = emo; e.fo = efo; e.mm = emm; e.roe = eroe; e.bus = ebus; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (match_out !== e.mo || full_out !== e.fo || mm_pull !== e.mm || res_oe !== e.roe ||
          (e.roe && res_bus !== e.bus)) begin
        errors++;
        $display("FAIL %s: got mo=%b fo=%b mm=%b oe=%b bus=%0d, expected mo=%b fo=%b mm=%b oe=%b bus=%0d",
                 e.tag, match_out, full_out, mm_pull, res_oe, res_bus,
                 e.mo, e.fo, e.mm, e.roe, e.bus);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    {ce, sel, loc_hit, loc_multi, all_valid, match_in, oe, cfg_lowest} = '0;
    full_in = 1'b1; op = 2'b00; loc_idx = '0; free_idx = '0; acc_idx = '0; page = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R12 reset state
    step(2'b00,1,1,0,0,0, 0,0,0,0, 0,1,1,0, 0,0,0,0,0,   "R12");
    // R4 compare hit, top of chain
    step(2'b01,1,1,1,0,5, 0,0,0,3, 0,1,1,0, 1,0,0,1,197, "R4");
    // R3 two or more local matches
    step(2'b01,1,1,1,1,9, 0,0,0,3, 0,1,1,0, 1,0,1,1,201, "R3");
    // R3 with match_in high: single hit pulls; R1; R4 device releases
    step(2'b00,1,1,0,0,0, 0,0,0,3, 1,1,1,0, 1,0,1,0,0,   "R3");
    // R11 oe low
    step(2'b00,1,1,0,0,0, 0,0,0,3, 0,1,0,0, 1,0,1,0,0,   "R11");
    // R9 no-op keeps captured page:index despite new page
    step(2'b00,1,1,0,0,0, 0,0,0,7, 0,1,1,0, 1,0,1,1,201, "R9");
    // R1 compare hit while upstream matched
    step(2'b01,1,1,1,0,4, 0,0,0,3, 1,1,1,0, 1,0,1,0,0,   "R1");
    // R8 deselected compare clears hit
    step(2'b01,1,0,1,1,4, 0,0,0,3, 0,1,1,0, 0,0,0,0,0,   "R8");
    // R5 lowest device drives ones on system miss
    step(2'b00,1,1,0,0,0, 0,0,0,3, 0,1,1,1, 0,0,0,1,1023,"R5");
    // R5 upstream matched: lowest stays off
    step(2'b00,1,1,0,0,0, 0,0,0,3, 1,1,1,1, 1,0,0,0,0,   "R5");
    // R10 ce low blocks a compare
    step(2'b01,0,1,1,1,2, 0,0,0,3, 0,1,1,1, 0,0,0,1,1023,"R10");
    // R2 full flag gating
    step(2'b00,1,1,0,0,0, 1,0,0,3, 0,1,0,1, 0,1,0,0,0,   "R2");
    step(2'b00,1,1,0,0,0, 1,0,0,3, 0,0,0,1, 0,0,0,0,0,   "R2");
    // R6 next-free write lands here
    step(2'b10,1,1,0,0,0, 0,12,0,2, 0,1,1,0, 0,0,0,1,140, "R6");
    // R6 upstream still has room: not owner
    step(2'b10,1,1,0,0,0, 0,12,0,2, 0,0,1,1, 0,0,0,0,0,   "R6");
    // R6 system full: lowest drives ones
    step(2'b10,1,1,0,0,0, 1,12,0,2, 0,1,1,1, 0,1,0,1,1023,"R6");
    // R7 random access owns bus regardless of chain
    step(2'b11,1,1,0,0,0, 0,0,33,1, 1,1,1,0, 1,0,0,1,97,  "R7");
    step(2'b11,1,0,0,0,0, 0,0,33,1, 0,1,1,0, 0,0,0,0,0,   "R7");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule